// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block keeps one sticky status flag for each of fourteen external interrupt request lines, numbered 0 to 11, 14 and 15. Each request input first passes through a synchronizer. A 2-bit select for each line then picks the condition that sets the line's flag: a low level, a falling edge, a rising edge, or either edge. The flags drive one output bit per line, which an external priority encoder samples. Software can read the same flags through a 16-bit register port.

Software clears a flag in two steps. It first reads the register and sees the flag as 1, and that read arms the flag. It then writes 0 to the flag's bit position. Any write disarms every flag, so a stale read cannot enable a later clear. When a line is set to falling-edge sensing, a one-cycle acknowledge pulse for that line also clears its flag. If a new detection arrives in the same cycle as a clear, the detection wins, so no request is lost.

Top module: `irq_flag_reg`

## Requirements
- R1: Asserting reset clears every flag, so `flag_o` and `rdata_o` read 0 after reset, also when flags were set before reset.
- R2: Bit positions 13 and 12 are reserved. They always read 0 on `rdata_o` and `flag_o`, whatever happens on their request, mode, acknowledge or write inputs.
- R3: Sense code 2'b00 (low level) sets the flag while the synchronized input is low. While the input stays low, a read followed by a 0-write leaves the flag at 1. After the input returns high, the same sequence clears it.
- R4: Sense code 2'b01 (falling edge) sets the flag only on a high-to-low transition. An input that stays high, or rises, leaves the flag at 0.
- R5: Sense code 2'b10 (rising edge) sets the flag only on a low-to-high transition. Sense code 2'b11 (both edges) sets it on either transition.
- R6: An input change made before clock edge 1 appears on the flag after clock edge 3 and not after edge 2: two synchronizer stages plus the flag register.
- R7: A write with bit i at 0 clears flag i only if a read returned bit i as 1 after the last write. A 0-write with no earlier read, and a write with bit i at 1, leave the flag unchanged.
- R8: Any write disarms all flags, so a second 0-write after a write does not clear a flag without a new read.
- R9: A one-cycle pulse on `ack_i[i]` clears flag i when line i uses sense code 2'b01. In any other sense mode the pulse has no effect.
- R10: When a detection and a clear occur in the same cycle, the flag ends at 1.
- R11: `flag_o` equals the value read on `rdata_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| req_i | input | 16 | Request lines, indexed by line number. Bits 13 and 12 are ignored. |
| sense_i | input | 32 | 2-bit sense code per line, at bits [2i+1:2i] |
| ack_i | input | 16 | Per-line acknowledge strobe, one cycle wide |
| rd_en_i | input | 1 | Register read strobe. Arms every flag that reads as 1. |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data. A 0 clears an armed flag. |
| rdata_o | output | 16 | Current flag register value |
| flag_o | output | 16 | Per-line flag outputs for the priority encoder |

## Verification
The embedded assertions check, on every cycle, the rules that hold for one flag at a time:
- a detection always leaves the flag set, whatever clear arrives with it;
- a flag never rises without a detection;
- a write to an unarmed flag does not clear it;
- an acknowledge outside falling-edge mode does not clear the flag;
- a write always disarms;
- the reserved bits stay at zero.

Other behaviours need a sequence of stimulus that only the bench's scenarios build:
- which transitions each sense mode turns into a flag;
- the exact three-edge latency;
- the read, write, write-again ordering of the clear handshake;
- the level-mode flag that holds while its input is low;
- reset that wipes flags which were set before it.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  sense_e mode_i,
  output logic   hit_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   cur;

  // Sampling chain and delayed copy of the synchronized level
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], req_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  // Lines idle high, so the chain resets to 1 and no edge is seen after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  hit_o = !cur;
      SENSE_FALL: hit_o = prev_q && !cur;
      SENSE_RISE: hit_o = !prev_q && cur;
      default:    hit_o = prev_q ^ cur;
    endcase
  end

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic ack_i,
  input  logic fall_mode_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d, arm_en;
  logic sw_clr, ack_clr;

  // Next-state logic
  always_comb begin
    sw_clr  = wr_i && arm_q && !wbit_i;
    ack_clr = ack_i && fall_mode_i;
    flag_en = hit_i || sw_clr || ack_clr;
    flag_d  = hit_i;
    arm_en  = wr_i || (rd_i && flag_q);
    arm_d   = !wr_i;
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q); // R10
  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !hit_i) |=> !flag_q); // R4
  AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_i && !arm_q && !(ack_i && fall_mode_i)) |=> flag_q); // R7
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !arm_q); // R8
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ack_i && !fall_mode_i && !wr_i) |=> flag_q); // R9

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int                REG_W       = 16,
  parameter logic [REG_W-1:0]  IMPL_MASK   = 16'hCFFF,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     req_i,
  input  logic [2*REG_W-1:0]   sense_i,
  input  logic [REG_W-1:0]     ack_i,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [REG_W-1:0]     flag_o
);

  localparam int MODE_W = 2;

  logic             rst_sn;
  logic [REG_W-1:0] hit;
  logic [REG_W-1:0] flag_bits;

  irq_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_line
    sense_e mode;
    assign mode = sense_e'(sense_i[MODE_W*i +: MODE_W]);

    if (IMPL_MASK[i]) begin : g_impl
      irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_det (
        .clk    (clk),
        .rst_n  (rst_sn),
        .req_i  (req_i[i]),
        .mode_i (mode),
        .hit_o  (hit[i])
      );

      irq_flag_cell i_cell (
        .clk         (clk),
        .rst_n       (rst_sn),
        .hit_i       (hit[i]),
        .ack_i       (ack_i[i]),
        .fall_mode_i (mode == SENSE_FALL),
        .rd_i        (rd_en_i),
        .wr_i        (wr_en_i),
        .wbit_i      (wdata_i[i]),
        .flag_o      (flag_bits[i])
      );
    end else begin : g_rsvd
      logic unused_rsvd;
      assign hit[i]       = 1'b0;
      assign flag_bits[i] = 1'b0;
      assign unused_rsvd  = ^{req_i[i], ack_i[i], wdata_i[i], mode, hit[i]};
    end
  end

  assign rdata_o = flag_bits;
  assign flag_o  = flag_bits;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (rdata_o & ~IMPL_MASK) == '0); // R2

endmodule

// File: tb/test_irq_flag_reg.sv
`timescale 1ns/1ps
module test_irq_flag_reg;
  import irq_flag_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req;
  logic [31:0] sense;
  logic [15:0] ack;
  logic        rd_en;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [15:0] flag;
  logic [15:0] rd_val;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_flag_reg i_irq_flag_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .sense_i (sense),
    .ack_i   (ack),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .flag_o  (flag)
  );

  // Vector fields: {line[4:0], mode[1:0], lvl1, lvl2, expected}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {5'd0,  2'b01, 1'b0, 1'b0, 1'b1},
    {5'd1,  2'b01, 1'b1, 1'b1, 1'b0},
    {5'd2,  2'b10, 1'b0, 1'b0, 1'b0},
    {5'd3,  2'b10, 1'b0, 1'b1, 1'b1},
    {5'd4,  2'b11, 1'b0, 1'b0, 1'b1},
    {5'd5,  2'b11, 1'b1, 1'b1, 1'b0},
    {5'd7,  2'b11, 1'b0, 1'b1, 1'b1},
    {5'd14, 2'b00, 1'b0, 1'b1, 1'b1},
    {5'd15, 2'b00, 1'b1, 1'b1, 1'b0},
    {5'd11, 2'b01, 1'b0, 1'b1, 1'b1},
    {5'd13, 2'b01, 1'b0, 1'b0, 1'b0},
    {5'd12, 2'b00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int line, input logic [1:0] m);
    sense[2*line +: 2] = m;
  endtask

  task automatic set_all_modes(input logic [1:0] m);
    for (int k = 0; k < 16; k++) sense[2*k +: 2] = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = 16'hFFFF;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic reg_read(output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req   = 16'hFFFF;
    sense = '0;
    ack   = '0;
    rd_en = 1'b0;
    wr_en = 1'b0;
    wdata = '0;
    set_all_modes(2'b01);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 reset flags", flag, 16'h0000);
    chk("R1 reset rdata", rdata, 16'h0000);

    // Vector table: each entry starts from reset with all inputs high
    for (int v = 0; v < NV; v++) begin
      logic [4:0]  ln;
      logic [15:0] exp;
      ln = VEC[v][9:5];
      set_all_modes(VEC[v][4:3]);
      do_reset();
      req[ln] = VEC[v][2];
      wait_n(5);
      req[ln] = VEC[v][1];
      wait_n(5);
      exp = (VEC[v][0] ? 16'h0001 : 16'h0000) << ln;
      chk("R3/R4/R5 mode vector", flag, exp);
      chk("R11 flag matches rdata", rdata, exp);
      chk("R2 reserved read zero", rdata & 16'h3000, 16'h0000);
    end

    // R6 latency, falling mode on line 6
    set_all_modes(2'b01);
    do_reset();
    @(negedge clk);
    req[6] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R6 not yet after edge 2", flag, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk("R6 set after edge 3", flag, 16'h0040);

    // R7 / R8 clear handshake on line 2
    do_reset();
    req[2] = 1'b0;
    wait_n(5);
    chk("R4 fall sets line 2", flag, 16'h0004);
    reg_write(16'h0000);
    chk("R7 write 0 without read", flag, 16'h0004);
    reg_read(rd_val);
    chk("R7 read returns flag", rd_val, 16'h0004);
    reg_write(16'hFFFF);
    chk("R7 write 1 no change", flag, 16'h0004);
    reg_write(16'h0000);
    chk("R8 second write after disarm", flag, 16'h0004);
    reg_read(rd_val);
    reg_write(16'h0000);
    chk("R7 armed write 0 clears", flag, 16'h0000);

    // R9 acknowledge: falling line 0 clears, rising line 1 holds
    do_reset();
    set_mode(1, 2'b10);
    req[0] = 1'b0;
    req[1] = 1'b0;
    wait_n(5);
    req[1] = 1'b1;
    wait_n(5);
    chk("R9 both flags set", flag, 16'h0003);
    ack = 16'h0003;
    @(negedge clk);
    ack = 16'h0000;
    chk("R9 ack clears only falling line", flag, 16'h0002);

    // R3 low level holds against clear
    do_reset();
    set_mode(4, 2'b00);
    req[4] = 1'b0;
    wait_n(5);
    reg_read(rd_val);
    reg_write(16'h0000);
    chk("R3 level still low keeps flag", flag, 16'h0010);
    req[4] = 1'b1;
    wait_n(5);
    reg_read(rd_val);
    reg_write(16'h0000);
    chk("R3 level high then clear", flag, 16'h0000);

    // R10 detection in the same cycle as an armed clear
    do_reset();
    set_mode(5, 2'b11);
    req[5] = 1'b0;
    wait_n(5);
    reg_read(rd_val);
    chk("R10 armed read", rd_val, 16'h0020);
    req[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 set wins over clear", flag, 16'h0020);

    // R2 reserved lines ignore everything
    do_reset();
    set_all_modes(2'b00);
    req = 16'hFFFF & ~16'h3000;
    ack = 16'h3000;
    wait_n(5);
    reg_write(16'h3000);
    reg_read(rd_val);
    chk("R2 reserved bits stay zero", rd_val, 16'h0000);
    ack = 16'h0000;

    // R1 reset wipes set flags
    set_all_modes(2'b01);
    do_reset();
    req[9] = 1'b0;
    req[15] = 1'b0;
    wait_n(5);
    chk("R1 flags set before reset", flag, 16'h8200);
    do_reset();
    chk("R1 flags cleared by reset", flag, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule